// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Register Block

This block holds the control state for one general-purpose I/O port and sits between a simple synchronous register bus and the pad ring. Software sets each pin's direction, the value the pin drives, whether its digital input is cut off for analog use, and whether a weak pull-up is on. On the pad side the block produces a drive value, a drive enable and a pull-up enable for every pin.

The latch and the pin levels are read back at different addresses. The latch address returns the stored drive value. The port-data address returns what is really on the pins, after a two-flop synchronizer. A write to either address lands in the latch. An on-chip peripheral can take over the drive of any pin. That pin can still be read through the port-data address, and its latch keeps its value.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF (all inputs) and the analog-select register reads 0xFF. The latch reads 0x00 and the pull-up register reads 0x00. All outputs pin_oe and pin_pu are 0.
- R2: A write with wr_en=1 to address 0 (port data) or address 1 (latch) stores wr_data in the latch at that clock edge. Reading address 1 returns the latch contents.
- R3: Reading address 0 returns the pin levels. Each pin passes through two flops, so a change on pin_in is visible after the second rising clock edge and not after the first.
- R4: A direction bit of 1 makes the pin an input and a 0 makes it an output. With no peripheral override, pin_oe[i] equals the inverse of direction bit i.
- R5: For every pin whose analog-select bit is 1, bit i of a port-data read (address 0) is 0, whatever level is on the pin.
- R6: While periph_en[i] is 1, pin_oe[i] is 1 and pin_out[i] follows periph_out[i]. The latch keeps its value, and the pin level can still be read at address 0.
- R7: While periph_en[i] is 0, pin_out[i] equals latch bit i, whatever the direction bit.
- R8: Address 4 holds the pull-up enables. pin_pu reflects that register, and reading address 4 returns it.
- R9: Reads of addresses 5 to 7 return 0, and writes to them change no register.
- R10: Address 2 reads back the direction register and address 3 reads back the analog-select register. Each holds the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| periph_en | input | 8 | Per-pin peripheral drive override |
| periph_out | input | 8 | Peripheral drive values |

## Verification
The port-data path is driven with the complementary patterns 0xA5 and 0x5A. This shows that each bit goes through on its own, and it catches inverted or swapped bits. Each pattern is sampled after one edge and again after two, which pins down the synchronizer depth exactly. An analog-select mask of 0x0F applied over 0x5A must give 0x50, which separates the gating from the raw pin value. The latch is written through both of its addresses with distinct values, and peripheral overrides are placed on the two end pins only. This shows that the override is per pin and that it leaves the latch readback untouched.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      ADR_PORT  = 3'd0,
      ADR_LATCH = 3'd1,
      ADR_DIR   = 3'd2,
      ADR_ANSEL = 3'd3,
      ADR_PULL  = 3'd4
   } gpio_addr_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit HAS_PULLUP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  rd_data,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  ansel_q,
   output logic [WIDTH-1:0]  pull_q
);
   logic sel_latch, sel_dir, sel_ansel;

   assign sel_latch = wr_en && (addr == ADR_PORT || addr == ADR_LATCH);
   assign sel_dir   = wr_en && (addr == ADR_DIR);
   assign sel_ansel = wr_en && (addr == ADR_ANSEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '1;
         ansel_q <= '1;
      end else begin
         if (sel_latch) latch_q <= wr_data;
         if (sel_dir)   dir_q   <= wr_data;
         if (sel_ansel) ansel_q <= wr_data;
      end
   end

   generate
      if (HAS_PULLUP) begin : g_pull
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         pull_q <= '0;
            else if (wr_en && addr == ADR_PULL) pull_q <= wr_data;
         end
      end else begin : g_no_pull
         assign pull_q = '0;
      end
   endgenerate

   always_comb begin
      case (addr)
         ADR_PORT:  rd_data = pin_sync & ~ansel_q;
         ADR_LATCH: rd_data = latch_q;
         ADR_DIR:   rd_data = dir_q;
         ADR_ANSEL: rd_data = ansel_q;
         ADR_PULL:  rd_data = pull_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_pad_ctl.sv
module gpio_port_pad_ctl #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] periph_en,
   input  logic [WIDTH-1:0] periph_out,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_pu
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         assign pin_oe[i]  = periph_en[i] | ~dir_q[i];
         assign pin_out[i] = periph_en[i] ? periph_out[i] : latch_q[i];
         assign pin_pu[i]  = pull_q[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PULLUP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_pu,
   input  logic [WIDTH-1:0]  periph_en,
   input  logic [WIDTH-1:0]  periph_out
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("gpio_port: WIDTH must be 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pin_sync;
   logic [WIDTH-1:0] latch_q, dir_q, ansel_q, pull_q;

   gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   gpio_port_regs #(.WIDTH(WIDTH), .HAS_PULLUP(HAS_PULLUP)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .pin_sync(pin_sync), .rd_data(rd_data),
      .latch_q(latch_q), .dir_q(dir_q), .ansel_q(ansel_q), .pull_q(pull_q)
   );

   gpio_port_pad_ctl #(.WIDTH(WIDTH)) u_pad (
      .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
      .periph_en(periph_en), .periph_out(periph_out),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       addr,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] rd_data,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] periph_en,
   input logic [WIDTH-1:0] periph_out,
   input logic [WIDTH-1:0] latch_q,
   input logic [WIDTH-1:0] dir_q,
   input logic [WIDTH-1:0] ansel_q
);
   logic [WIDTH-1:0] pin_dly [STAGES];
   int unsigned      cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= 0;
         for (int k = 0; k < STAGES; k++) pin_dly[k] <= '0;
      end else begin
         if (cyc < STAGES + 1) cyc <= cyc + 1;
         pin_dly[0] <= pin_in;
         for (int k = 1; k < STAGES; k++) pin_dly[k] <= pin_dly[k-1];
      end
   end

   AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr <= 3'd1) |=> latch_q == $past(wr_data)); // R2
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || addr > 3'd1) |=> $stable(latch_q)); // R9
   AST_PORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= STAGES && addr == 3'd0) |-> rd_data == (pin_dly[STAGES-1] & ~ansel_q)); // R3
   AST_OE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe == (periph_en | ~dir_q)); // R4
   AST_DRIVE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out == ((periph_en & periph_out) | (~periph_en & latch_q))); // R6
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr > 3'd4) |-> rd_data == '0); // R9
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
   .periph_en(periph_en), .periph_out(periph_out), .latch_q(latch_q),
   .dir_q(dir_q), .ansel_q(ansel_q)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out, pin_oe, pin_pu;
   logic [7:0] periph_en = '0;
   logic [7:0] periph_out = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_pu(pin_pu), .periph_en(periph_en), .periph_out(periph_out)
   );

   task automatic check(input string req, input [7:0] act, input [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input [2:0] a, input [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input [2:0] a, output [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      pin_in = 8'hFF;
      rd(3'd2, v); check("R1 dir reset", v, 8'hFF);
      rd(3'd3, v); check("R1 ansel reset", v, 8'hFF);
      rd(3'd1, v); check("R1 latch reset", v, 8'h00);
      rd(3'd4, v); check("R1 pull reset", v, 8'h00);
      check("R1 oe reset", pin_oe, 8'h00);
      check("R1 pu reset", pin_pu, 8'h00);
      repeat (3) @(negedge clk);
      rd(3'd0, v); check("R5 analog masks all pins", v, 8'h00);
      pin_in = 8'h00;
   endtask

   task automatic t_latch();
      logic [7:0] v;
      wr(3'd1, 8'h3C);
      rd(3'd1, v); check("R2 latch via latch address", v, 8'h3C);
      wr(3'd0, 8'hC3);
      rd(3'd1, v); check("R2 latch via port address", v, 8'hC3);
      check("R7 pin_out from latch", pin_out, 8'hC3);
   endtask

   task automatic t_dir();
      logic [7:0] v;
      wr(3'd2, 8'h38);
      rd(3'd2, v); check("R10 dir readback", v, 8'h38);
      check("R4 oe from direction", pin_oe, 8'hC7);
      wr(3'd3, 8'h00);
      rd(3'd3, v); check("R10 ansel readback", v, 8'h00);
   endtask

   task automatic t_port();
      logic [7:0] v;
      @(negedge clk); addr = 3'd0; pin_in = 8'hA5;
      @(negedge clk); #1 check("R3 not visible after one edge", rd_data, 8'h00);
      @(negedge clk); #1 check("R3 visible after two edges", rd_data, 8'hA5);
      @(negedge clk); pin_in = 8'h5A;
      @(negedge clk); #1 check("R3 old value after one edge", rd_data, 8'hA5);
      @(negedge clk); #1 check("R3 new value after two edges", rd_data, 8'h5A);
      wr(3'd3, 8'h0F);
      rd(3'd0, v); check("R5 analog bits read zero", v, 8'h50);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_periph();
      logic [7:0] v;
      wr(3'd2, 8'hFF);
      wr(3'd1, 8'h00);
      @(negedge clk);
      periph_en = 8'h81; periph_out = 8'h01; pin_in = 8'h81;
      #1;
      check("R6 override enables drive", pin_oe, 8'h81);
      check("R6 override drives peripheral value", pin_out, 8'h01);
      repeat (2) @(negedge clk);
      rd(3'd1, v); check("R6 latch untouched", v, 8'h00);
      rd(3'd0, v); check("R6 overridden pin still readable", v, 8'h81);
      @(negedge clk); periph_en = 8'h00; periph_out = 8'h00;
      #1 check("R7 latch drives after release", pin_out, 8'h00);
   endtask

   task automatic t_pull();
      logic [7:0] v;
      wr(3'd4, 8'h55);
      check("R8 pull-up output", pin_pu, 8'h55);
      rd(3'd4, v); check("R8 pull-up readback", v, 8'h55);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      for (int a = 5; a < 8; a++) wr(3'(a), 8'hFF);
      for (int a = 5; a < 8; a++) begin
         rd(3'(a), v); check("R9 unmapped reads zero", v, 8'h00);
      end
      rd(3'd1, v); check("R9 latch unchanged", v, 8'h00);
      rd(3'd2, v); check("R9 dir unchanged", v, 8'hFF);
      rd(3'd3, v); check("R9 ansel unchanged", v, 8'h00);
      rd(3'd4, v); check("R9 pull unchanged", v, 8'h55);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch();
      t_dir();
      t_port();
      t_periph();
      t_pull();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule